// File: doc/BRIEF.md
# CDR Lock-Mode Sequencing Controller

This block decides whether a receiver's clock-data-recovery loop follows the local reference clock (LTR) or the incoming serial data (LTD). It also decides when the receive PCS may leave reset. The analog loop is not modelled. Its health reaches the controller only through five asynchronous status flags, and each flag passes through a two-flop synchronizer before use. After reset the loop first has to report lock to the reference. In automatic operation the controller then waits for three qualifiers to hold together before it switches to data lock: signal present, frequency within the PPM window, and phase matched. The frequency and phase flags only count after they have been steady for a run of consecutive cycles. The signal-detect flag is only consulted in PCI Express mode. In manual operation the qualifiers are bypassed and a software request drives the switch.

When the loop enters data mode, a settle window sized from the clock rate keeps the PCS in reset. The window lasts 1 ms by default. The PCS is released only when that window has elapsed and data lock is present. If data lock does not arrive within twice the settle time, the controller returns to reference lock and raises a sticky error. If data lock drops during normal running, the PCS goes back into reset and the sequence restarts. The mode inputs `pcie_mode_i`, `manual_mode_i` and `manual_ltd_req_i` are synchronous to `clk`.

Top module: `cdr_lock_seq`

## Requirements
- R1: During and after reset, `ltd_sel_o`=0 (0 selects LTR, 1 selects LTD), `pcs_rst_o`=1 and `timeout_err_o`=0. LTR stays selected while the synchronized reference-lock flag is low.
- R2: In automatic mode with reference lock present, LTD is selected only when the effective signal-detect, the qualified frequency flag and the qualified phase flag are all true together. A missing qualifier keeps LTR, and `ref_locked_o`=1 while waiting.
- R3: When `pcie_mode_i`=1, signal-detect gates the switch. When `pcie_mode_i`=0, signal-detect is treated as true whatever its level.
- R4: The frequency and phase flags count only after QUAL_LEN consecutive synchronized high samples. A shorter run followed by a low sample restarts the count.
- R5: Data lock has no effect while LTR is selected. Reference lock has no effect while LTD is selected.
- R6: With data lock present, `pcs_rst_o` falls exactly SETTLE_CYC cycles after `ltd_sel_o` rises, and never earlier. SETTLE_CYC = CLK_HZ/1000 × SETTLE_US/1000.
- R7: If the PCS has not been released 2×SETTLE_CYC cycles after `ltd_sel_o` rises, LTR is selected again on that cycle, `pcs_rst_o` stays 1, and `timeout_err_o` goes to 1 and stays there until reset.
- R8: With `manual_mode_i`=1, the qualifiers are ignored. After reference lock, LTD follows `manual_ltd_req_i`, the settle timing of R6 still applies, and dropping the request returns to LTR with the PCS in reset.
- R9: A loss of data lock while the PCS is released re-asserts `pcs_rst_o` and selects LTR three cycles after the pin falls: two synchronizer cycles and one state cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock at CLK_HZ |
| rst_n | input | 1 | Active-low receiver reset |
| ref_lock_i | input | 1 | Loop locked to the reference (async) |
| sig_det_i | input | 1 | Valid signal level detected (async) |
| freq_ok_i | input | 1 | Frequency within PPM threshold (async) |
| phase_ok_i | input | 1 | Phase matched to reference (async) |
| data_lock_i | input | 1 | Loop locked to data (async) |
| pcie_mode_i | input | 1 | 1 = PCI Express protocol, signal-detect used |
| manual_mode_i | input | 1 | 1 = manual mode select |
| manual_ltd_req_i | input | 1 | Manual request for data lock |
| ltd_sel_o | output | 1 | 0 = lock to reference, 1 = lock to data |
| pcs_rst_o | output | 1 | Receive PCS reset, active high |
| ref_locked_o | output | 1 | Reference locked, waiting for qualifiers or request |
| timeout_err_o | output | 1 | Sticky data-lock timeout flag |

## Verification
The hardest state to reach from the ports is a qualifier that keeps almost qualifying. The frequency flag is driven in runs one cycle shorter than QUAL_LEN, each broken by a single low cycle, while every other condition holds, so the run counter has to restart each time. The timeout path is also hard to reach, because it needs reference lock and all qualifiers held while data lock stays away for the whole doubled window. The bench shrinks CLK_HZ so that the window is 200 cycles, then measures the edge distances exactly.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;
    typedef enum logic [2:0] {
        ST_RESET      = 3'd0,
        ST_LTR_WAIT   = 3'd1,
        ST_LTR_LOCKED = 3'd2,
        ST_LTD_SETTLE = 3'd3,
        ST_LTD_RUN    = 3'd4
    } cdr_state_e;
endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/cdr_run_qual.sv
module cdr_run_qual #(
    parameter int N       = 2,
    parameter int RUN_LEN = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_i,
    output logic [N-1:0] ok_o
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(RUN_LEN);

    for (genvar g = 0; g < N; g++) begin : g_run
        logic [RW-1:0] run_d, run_q;

        always_comb begin
            if (!flag_i[g])            run_d = '0;
            else if (run_q == RUN_MAX) run_d = run_q;
            else                       run_d = run_q + 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) run_q <= '0;
            else        run_q <= run_d;
        end

        assign ok_o[g] = (run_q == RUN_MAX);
    end
endmodule

// File: rtl/cdr_lock_seq.sv
module cdr_lock_seq
    import cdr_lock_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int SETTLE_US = 1000,
    parameter int QUAL_LEN  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_lock_i,
    input  logic sig_det_i,
    input  logic freq_ok_i,
    input  logic phase_ok_i,
    input  logic data_lock_i,
    input  logic pcie_mode_i,
    input  logic manual_mode_i,
    input  logic manual_ltd_req_i,
    output logic ltd_sel_o,
    output logic pcs_rst_o,
    output logic ref_locked_o,
    output logic timeout_err_o
);
    localparam longint SETTLE_CYC  = longint'(CLK_HZ) / 1000 * SETTLE_US / 1000;
    localparam longint TIMEOUT_CYC = 2 * SETTLE_CYC;
    localparam int     CNT_W       = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        cdr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } ctl_t;

    // bit order: 0 ref, 1 sig, 2 freq, 3 phase, 4 data
    logic [4:0] sync_s;
    logic       ref_s, sig_s, data_s;
    logic [1:0] qual_ok;
    logic       auto_ok;
    logic       go_ltd;
    ctl_t       ctl_d, ctl_q;

    cdr_sync #(.W(5)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({data_lock_i, phase_ok_i, freq_ok_i, sig_det_i, ref_lock_i}),
        .sync_o (sync_s)
    );

    assign ref_s  = sync_s[0];
    assign sig_s  = sync_s[1];
    assign data_s = sync_s[4];

    cdr_run_qual #(.N(2), .RUN_LEN(QUAL_LEN)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .flag_i(sync_s[3:2]),
        .ok_o  (qual_ok)
    );

    assign auto_ok = (pcie_mode_i ? sig_s : 1'b1) & qual_ok[0] & qual_ok[1];
    assign go_ltd  = manual_mode_i ? manual_ltd_req_i : auto_ok;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_RESET: begin
                ctl_d.st  = ST_LTR_WAIT;
                ctl_d.cnt = '0;
            end
            ST_LTR_WAIT: begin
                if (ref_s) ctl_d.st = ST_LTR_LOCKED;
            end
            ST_LTR_LOCKED: begin
                if (!ref_s) begin
                    ctl_d.st = ST_LTR_WAIT;
                end else if (go_ltd) begin
                    ctl_d.st  = ST_LTD_SETTLE;
                    ctl_d.cnt = '0;
                end
            end
            ST_LTD_SETTLE: begin
                if (manual_mode_i && !manual_ltd_req_i) begin
                    ctl_d.st = ST_LTR_WAIT;
                end else if (ctl_q.cnt >= SETTLE_LAST && data_s) begin
                    ctl_d.st = ST_LTD_RUN;
                end else if (ctl_q.cnt == TIMEOUT_LAST) begin
                    ctl_d.st  = ST_LTR_WAIT;
                    ctl_d.err = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_LTD_RUN: begin
                if (!data_s || (manual_mode_i && !manual_ltd_req_i))
                    ctl_d.st = ST_LTR_WAIT;
            end
            default: ctl_d.st = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_RESET;
            ctl_q.cnt <= '0;
            ctl_q.err <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ltd_sel_o     = (ctl_q.st == ST_LTD_SETTLE) || (ctl_q.st == ST_LTD_RUN);
    assign pcs_rst_o     = (ctl_q.st != ST_LTD_RUN);
    assign ref_locked_o  = (ctl_q.st == ST_LTR_LOCKED);
    assign timeout_err_o = ctl_q.err;
endmodule

// File: rtl/cdr_lock_seq_chk.sv
module cdr_lock_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ltd_sel,
    input logic       pcs_rst,
    input logic       err,
    input logic       ref_s,
    input logic       data_s,
    input logic       auto_ok,
    input logic       manual
);
    // PCS may only run while the loop follows the data
    assert_pcs_only_in_ltd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pcs_rst |-> ltd_sel);

    // release needs synchronized data lock at the deciding edge
    assert_release_needs_dlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pcs_rst) |-> $past(data_s));

    // entry into data mode needs reference lock first
    assert_ltd_after_ref_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ltd_sel) |-> $past(ref_s));

    // automatic entry needs all qualifiers
    assert_auto_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ltd_sel) |-> ($past(auto_ok) || $past(manual)));

    // timeout drops back to reference with PCS held
    assert_timeout_to_ltr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($fell(ltd_sel) && pcs_rst));

    // error flag is sticky
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(err));
endmodule

bind cdr_lock_seq cdr_lock_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ltd_sel(ltd_sel_o),
    .pcs_rst(pcs_rst_o),
    .err    (timeout_err_o),
    .ref_s  (ref_s),
    .data_s (data_s),
    .auto_ok(auto_ok),
    .manual (manual_mode_i)
);

// File: tb/sim_cdr_lock_seq.sv
module sim_cdr_lock_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 100_000;
    localparam int SETTLE_US  = 1000;
    localparam int QUAL_LEN   = 4;
    localparam int SETTLE     = CLK_HZ / 1000 * SETTLE_US / 1000;
    localparam int TIMEOUT    = 2 * SETTLE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_lock = 0, sig_det = 0, freq_ok = 0, phase_ok = 0, data_lock = 0;
    logic pcie_mode = 0, manual_mode = 0, manual_req = 0;
    logic ltd_sel, pcs_rst, ref_locked, timeout_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdr_lock_seq #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .QUAL_LEN(QUAL_LEN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ref_lock_i(ref_lock), .sig_det_i(sig_det), .freq_ok_i(freq_ok),
        .phase_ok_i(phase_ok), .data_lock_i(data_lock),
        .pcie_mode_i(pcie_mode), .manual_mode_i(manual_mode),
        .manual_ltd_req_i(manual_req),
        .ltd_sel_o(ltd_sel), .pcs_rst_o(pcs_rst),
        .ref_locked_o(ref_locked), .timeout_err_o(timeout_err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150_000) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected=finish", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        {ref_lock, sig_det, freq_ok, phase_ok, data_lock} = '0;
        {pcie_mode, manual_mode, manual_req} = '0;
        tick(3);
        rst_n = 1;
    endtask

    // count negedges until ltd_sel reaches the wanted level
    task automatic wait_ltd(input logic lvl, input int lim, output int n);
        n = 0;
        while (ltd_sel != lvl && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic wait_pcs(input logic lvl, input int lim, output int n);
        n = 0;
        while (pcs_rst != lvl && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "ltd_sel after reset", ltd_sel, 0);
        check("R1", "pcs_rst after reset", pcs_rst, 1);
        check("R1", "err after reset", timeout_err, 0);
        freq_ok = 1; phase_ok = 1; sig_det = 1;
        tick(30);
        check("R1", "ltd_sel without ref lock", ltd_sel, 0);
    endtask

    task automatic t_dlock_in_ltr();
        do_reset();
        data_lock = 1;
        tick(25);
        check("R5", "pcs_rst with data lock in LTR", pcs_rst, 1);
        check("R5", "ltd_sel with data lock in LTR", ltd_sel, 0);
    endtask

    task automatic t_auto_settle();
        int n;
        do_reset();
        ref_lock = 1; freq_ok = 1; phase_ok = 1; data_lock = 1; sig_det = 0;
        wait_ltd(1, 40, n);
        check("R3", "switch with sig_det low, non-PCIe", ltd_sel, 1);
        wait_pcs(0, 400, n);
        check("R6", "settle cycles to PCS release", n, SETTLE);
    endtask

    task automatic t_partial();
        do_reset();
        ref_lock = 1; freq_ok = 1; phase_ok = 0; data_lock = 1;
        tick(40);
        check("R2", "no switch without phase", ltd_sel, 0);
        check("R2", "ref_locked while waiting", ref_locked, 1);
    endtask

    task automatic t_pcie();
        int n;
        do_reset();
        pcie_mode = 1; ref_lock = 1; freq_ok = 1; phase_ok = 1; sig_det = 0;
        tick(40);
        check("R3", "PCIe no switch without sig_det", ltd_sel, 0);
        sig_det = 1;
        wait_ltd(1, 20, n);
        check("R3", "PCIe switch with sig_det", ltd_sel, 1);
    endtask

    task automatic t_glitch();
        int n;
        int seen = 0;
        do_reset();
        ref_lock = 1; phase_ok = 1;
        tick(10);
        for (int p = 0; p < 10; p++) begin
            freq_ok = 1;
            for (int k = 0; k < QUAL_LEN - 1; k++) begin @(negedge clk); seen |= ltd_sel; end
            freq_ok = 0;
            @(negedge clk); seen |= ltd_sel;
        end
        tick(4);
        check("R4", "short frequency runs never qualify", seen | ltd_sel, 0);
        freq_ok = 1;
        wait_ltd(1, 30, n);
        check("R4", "steady frequency qualifies", ltd_sel, 1);
        check("R4", "qualify delay at least run length", int'(n >= QUAL_LEN), 1);
    endtask

    task automatic t_timeout();
        int n;
        do_reset();
        ref_lock = 1; freq_ok = 1; phase_ok = 1; data_lock = 0;
        wait_ltd(1, 40, n);
        wait_ltd(0, 600, n);
        check("R7", "timeout cycles", n, TIMEOUT);
        check("R7", "err after timeout", timeout_err, 1);
        check("R7", "pcs_rst after timeout", pcs_rst, 1);
        data_lock = 1;
        wait_pcs(0, 600, n);
        check("R7", "err sticky after later lock", timeout_err, 1);
    endtask

    task automatic t_ref_ignored_and_loss();
        int n;
        do_reset();
        ref_lock = 1; freq_ok = 1; phase_ok = 1; data_lock = 1;
        wait_pcs(0, 400, n);
        ref_lock = 0;
        tick(12);
        check("R5", "pcs_rst after ref loss in LTD", pcs_rst, 0);
        check("R5", "ltd_sel after ref loss in LTD", ltd_sel, 1);
        data_lock = 0;
        wait_pcs(1, 20, n);
        check("R9", "cycles to PCS reset on data loss", n, 3);
        check("R9", "ltd_sel after data loss", ltd_sel, 0);
    endtask

    task automatic t_manual();
        int n;
        do_reset();
        manual_mode = 1; manual_req = 0; ref_lock = 1; data_lock = 1;
        freq_ok = 1; phase_ok = 1;
        tick(30);
        check("R8", "manual, no request, qualifiers true", ltd_sel, 0);
        freq_ok = 0; phase_ok = 0;
        manual_req = 1;
        wait_ltd(1, 10, n);
        check("R8", "manual request selects LTD", ltd_sel, 1);
        wait_pcs(0, 400, n);
        check("R8", "manual settle cycles", n, SETTLE);
        manual_req = 0;
        tick(1);
        check("R8", "request drop selects LTR", ltd_sel, 0);
        check("R8", "request drop resets PCS", pcs_rst, 1);
    endtask

    initial begin
        t_reset();
        t_dlock_in_ltr();
        t_auto_settle();
        t_partial();
        t_pcie();
        t_glitch();
        t_timeout();
        t_ref_ignored_and_loss();
        t_manual();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule